// File: doc/BRIEF.md
# Three-Step Combination Lock Controller

This block is a clocked controller for a lock that opens only after three code values are entered in the right order. Three 4-bit code values are fixed at elaboration time. A one-hot select picks the value that the current step expects. A comparator checks that value against the one the user presents. A small state machine moves through three checking steps and ends either unlocked or in a latched error.

The user presents a value on `entry_value` and pulses `entry_strobe` high for one cycle. Each pulse uses up exactly one entered value. The state register is 4 bits wide, and its codes are chosen so that the outputs need no decode logic:

- The low three bits are the one-hot code select.
- The top bit is the unlocked indication.

Only a synchronous, active-high reset leaves the unlocked or error state.

Top module: `combo_lock_top`

## Requirements
- R1: A synchronous reset that is high at a rising edge puts the controller in the first step from any state: `code_sel` = 3'b001, `unlocked` = 0.
- R2: In a checking step, a cycle with `entry_strobe` low leaves `code_sel` and `unlocked` unchanged, whatever `entry_value` holds.
- R3: A strobe whose value equals the selected code advances first to second (`code_sel` 001 to 010) and second to third (010 to 100).
- R4: A matching strobe in the third step enters the unlocked state: `unlocked` = 1, `code_sel` = 3'b000.
- R5: A strobe whose value does not match the selected code, in any checking step, enters the error state: `code_sel` = 3'b000, `unlocked` = 0.
- R6: The unlocked and error states ignore strobes and values and hold until reset.
- R7: Select 001 compares against CODE_A, 010 against CODE_B and 100 against CODE_C. A value that is correct for another step does not advance the current one.
- R8: `code_sel` is always one-hot or zero. `unlocked` is 1 only in the unlocked state, and only while `code_sel` is zero.
- R9: The outputs change one clock edge after the strobe that causes the transition; there is no combinational path from the inputs to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| entry_value | input | VAL_W | Value presented by the user |
| entry_strobe | input | 1 | One-cycle pulse: consume `entry_value` |
| code_sel | output | 3 | One-hot select of the expected code; zero when not checking |
| unlocked | output | 1 | 1 only in the unlocked state |

## Verification
On every cycle, the assertions check these properties:

- The select is always one-hot or zero.
- `unlocked` and a non-zero select never appear together.
- The outputs hold steady when no strobe arrives.
- A mismatch lands in the error state.
- The two terminal states persist, and reset returns the controller to the first step.

Only the bench's scenarios can show the following:

- That each step compares against the right code value. This is swept over every possible entered value at each of the three steps.
- That the full correct sequence unlocks.
- That values belonging to another step are rejected.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int SEL_W = 3;
  localparam int STATE_W = SEL_W + 1;

  // Encoding: bit 3 drives unlocked, bits 2:0 drive the code select.
  typedef enum logic [STATE_W-1:0] {
    LK_ERR    = 4'b0000,
    LK_STEP1  = 4'b0001,
    LK_STEP2  = 4'b0010,
    LK_STEP3  = 4'b0100,
    LK_OPEN   = 4'b1000
  } lock_state_e;
endpackage

// File: rtl/code_select.sv
module code_select #(
  parameter int VAL_W = 4,
  parameter logic [VAL_W-1:0] CODE_A = 4'h3,
  parameter logic [VAL_W-1:0] CODE_B = 4'hA,
  parameter logic [VAL_W-1:0] CODE_C = 4'h6
) (
  input  logic [combo_lock_pkg::SEL_W-1:0] sel,
  output logic [VAL_W-1:0]                 ref_value
);
  localparam int N = combo_lock_pkg::SEL_W;
  logic [VAL_W-1:0] code_tbl [N];
  logic [VAL_W-1:0] masked   [N];

  assign code_tbl[0] = CODE_A;
  assign code_tbl[1] = CODE_B;
  assign code_tbl[2] = CODE_C;

  // AND-OR multiplexer driven directly by the one-hot select.
  for (genvar g = 0; g < N; g++) begin : g_leg
    assign masked[g] = code_tbl[g] & {VAL_W{sel[g]}};
  end

  always_comb begin
    ref_value = '0;
    for (int i = 0; i < N; i++) ref_value = ref_value | masked[i];
  end
endmodule

// File: rtl/value_compare.sv
module value_compare #(
  parameter int VAL_W = 4
) (
  input  logic [VAL_W-1:0] lhs,
  input  logic [VAL_W-1:0] rhs,
  output logic             equal
);
  assign equal = (lhs == rhs);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic match,
  output logic [combo_lock_pkg::STATE_W-1:0] state_bits
);
  import combo_lock_pkg::*;

  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_STEP1: if (strobe) state_d = match ? LK_STEP2 : LK_ERR;
      LK_STEP2: if (strobe) state_d = match ? LK_STEP3 : LK_ERR;
      LK_STEP3: if (strobe) state_d = match ? LK_OPEN  : LK_ERR;
      LK_OPEN:  state_d = LK_OPEN;
      LK_ERR:   state_d = LK_ERR;
      default:  state_d = LK_ERR;  // any illegal code falls to error
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_STEP1;
    else     state_q <= state_d;
  end

  assign state_bits = state_q;
endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top #(
  parameter int VAL_W = 4,
  parameter logic [VAL_W-1:0] CODE_A = 4'h3,
  parameter logic [VAL_W-1:0] CODE_B = 4'hA,
  parameter logic [VAL_W-1:0] CODE_C = 4'h6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] entry_value,
  input  logic             entry_strobe,
  output logic [2:0]       code_sel,
  output logic             unlocked
);
  import combo_lock_pkg::*;

  logic [STATE_W-1:0] state_bits;
  logic [VAL_W-1:0]   ref_value;
  logic               match_hit;

  code_select #(.VAL_W(VAL_W), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_C(CODE_C)) sel_i (
    .sel(state_bits[SEL_W-1:0]),
    .ref_value(ref_value)
  );

  value_compare #(.VAL_W(VAL_W)) cmp_i (
    .lhs(entry_value),
    .rhs(ref_value),
    .equal(match_hit)
  );

  lock_fsm fsm_i (
    .clk(clk),
    .rst(rst),
    .strobe(entry_strobe),
    .match(match_hit),
    .state_bits(state_bits)
  );

  // Outputs are plain wires from state bits: no decode (R9).
  assign code_sel = state_bits[SEL_W-1:0];
  assign unlocked = state_bits[STATE_W-1];
endmodule

// File: rtl/combo_lock_checker.sv
module combo_lock_checker (
  input logic       clk,
  input logic       rst,
  input logic       entry_strobe,
  input logic       match,
  input logic [2:0] code_sel,
  input logic       unlocked
);
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(code_sel));

  p_open_closed_sel_r8: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (code_sel == 3'b000));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !entry_strobe |=> ($stable(code_sel) && $stable(unlocked)));

  p_mismatch_err_r5: assert property (@(posedge clk) disable iff (rst)
    (entry_strobe && !match && code_sel != 3'b000) |=> (code_sel == 3'b000 && !unlocked));

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (entry_strobe && match && code_sel == 3'b001) |=> (code_sel == 3'b010));

  p_unlock_r4: assert property (@(posedge clk) disable iff (rst)
    (entry_strobe && match && code_sel == 3'b100) |=> (unlocked && code_sel == 3'b000));

  p_open_hold_r6: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 3'b000 && !unlocked) |=> (code_sel == 3'b000 && !unlocked));

  p_reset_entry_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (code_sel == 3'b001 && !unlocked));
endmodule

bind combo_lock_top combo_lock_checker chk_i (
  .clk(clk),
  .rst(rst),
  .entry_strobe(entry_strobe),
  .match(match_hit),
  .code_sel(code_sel),
  .unlocked(unlocked)
);

// File: tb/combo_lock_top_tb_top.sv
`timescale 1ns/1ps
module combo_lock_top_tb_top;
  localparam int VAL_W = 4;
  localparam logic [VAL_W-1:0] CA = 4'h3;
  localparam logic [VAL_W-1:0] CB = 4'hA;
  localparam logic [VAL_W-1:0] CC = 4'h6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VAL_W-1:0] entry_value = '0;
  logic entry_strobe = 1'b0;
  logic [2:0] code_sel;
  logic unlocked;

  int n_checks = 0;
  int n_fail = 0;
  int step_idx = 0;  // model: 0..2 checking, 3 unlocked, 4 error
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  combo_lock_top #(.VAL_W(VAL_W), .CODE_A(CA), .CODE_B(CB), .CODE_C(CC)) dut_i (
    .clk(clk), .rst(rst), .entry_value(entry_value),
    .entry_strobe(entry_strobe), .code_sel(code_sel), .unlocked(unlocked)
  );

  function automatic logic [VAL_W-1:0] code_of(int k);
    return (k == 0) ? CA : (k == 1) ? CB : CC;
  endfunction

  task automatic check(string req);
    logic [2:0] es;
    logic eo;
    es = (step_idx < 3) ? 3'(1 << step_idx) : 3'b000;
    eo = (step_idx == 3);
    n_checks++;
    if (code_sel !== es || unlocked !== eo) begin
      n_fail++;
      $display("FAIL %s: sel=%b open=%b expected sel=%b open=%b", req, code_sel, unlocked, es, eo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step_idx = 0;
  endtask

  // One strobe; model updates; outputs sampled at the next falling edge (R9).
  task automatic enter(logic [VAL_W-1:0] v);
    @(negedge clk); entry_value = v; entry_strobe = 1'b1;
    if (step_idx < 3) step_idx = (v == code_of(step_idx)) ? step_idx + 1 : 4;
    @(negedge clk); entry_strobe = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); entry_value = VAL_W'(i * 5 + 1);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: sel=%b open=%b expected completion", code_sel, unlocked);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset state");

    // Sweep every value at every step: R3, R4, R5, R7
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        for (int j = 0; j < k; j++) enter(code_of(j));
        check("R3 prefix");
        enter(VAL_W'(v));
        check(k == 2 ? "R4/R5/R7 third step" : "R3/R5/R7 step");
      end
    end

    // R2: idle cycles with changing value do nothing, in each checking step
    for (int k = 0; k < 3; k++) begin
      do_reset();
      for (int j = 0; j < k; j++) enter(code_of(j));
      idle(6);
      check("R2 idle hold");
    end

    // R7: the right value for another step is rejected
    do_reset(); enter(CB); check("R7 step1 rejects CODE_B");
    do_reset(); enter(CA); enter(CC); check("R7 step2 rejects CODE_C");
    do_reset(); enter(CA); enter(CB); enter(CA); check("R7 step3 rejects CODE_A");

    // R6/R8: unlocked state ignores strobes, then reset leaves it (R1)
    do_reset(); enter(CA); enter(CB); enter(CC);
    check("R4 unlocked");
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); entry_value = VAL_W'(v); entry_strobe = 1'b1;
    end
    @(negedge clk); entry_strobe = 1'b0;
    check("R6 unlocked holds");
    do_reset(); check("R1 reset from unlocked");

    // R6: error state ignores even the correct sequence
    enter(4'hF); check("R5 error");
    step_idx = 4;
    @(negedge clk); entry_value = CA; entry_strobe = 1'b1;
    @(negedge clk); entry_value = CB;
    @(negedge clk); entry_value = CC;
    @(negedge clk); entry_strobe = 1'b0;
    check("R6 error holds");
    do_reset(); check("R1 reset from error");

    // R1: reset mid-sequence
    enter(CA); enter(CB); check("R3 third step");
    do_reset(); check("R1 reset from third step");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule